// File: doc/BRIEF.md
# Programmable memory wait-state generator

This block sits between a processor bus and three memory regions: flash, RAM and video RAM. It does not store any memory data. It only produces access timing. When a request is accepted, the block holds `ready_o` low for a number of wait cycles and then raises it for one cycle to complete the access. The number of wait cycles depends on which region the address falls in and on whether the access is a read or a write.

Flash accesses always take a fixed base of five wait cycles. On top of that base they add a number held in an 8-bit control register, which software can change. RAM and video RAM use fixed counts: three wait cycles for a read and one for a write. The control register sits at its own bus address and is reached with the same request/ready handshake. Accesses to it complete with no wait cycles.

The address map is as follows:
- Flash covers addresses below `FLASH_TOP`, which defaults to 0x400000.
- The control register sits at `CTRL_ADDR`, which defaults to 0xE00005.
- Every other address is treated as RAM or video RAM.

Top module: `mem_wait_gen`

## Requirements
- R1: After reset, `ready_o` is low and the control register holds 0x04. A register read issued straight after reset returns 0x04.
- R2: A flash read holds `ready_o` low for 5 plus the register value cycles and then raises it for one cycle. With the reset value 0x04 this gives 9 wait cycles, or 10 cycles in total.
- R3: A read from RAM or video RAM (any address at or above `FLASH_TOP` other than `CTRL_ADDR`) gets 3 wait cycles.
- R4: A write to RAM or video RAM gets 1 wait cycle.
- R5: A flash write gets the same wait count as a flash read with the same register value.
- R6: An access to `CTRL_ADDR` gets 0 wait cycles: `ready_o` is high in the cycle after acceptance. A write stores all 8 bits of `wdata_i`. A read returns the last value written on `rdata_o` during its ready cycle.
- R7: Register values 0x00 and 0xFF are legal. They give flash waits of 5 and 260 respectively.
- R8: The wait count is fixed when a request is accepted. A request presented while an access is in progress is ignored, including a register write. That write does not change the register and does not change the current access.
- R9: A request presented in the cycle where `ready_o` is high is accepted at the end of that cycle, so accesses can follow each other back to back.
- R10: `ready_o` is high for exactly one cycle per accepted request. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request, sampled when no access is in progress |
| addr_i | input | ADDR_W | Access address, used to select the region |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | DATA_W | Write data for the control register |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Control register read data, valid in the ready cycle |

## Verification
A request sampled at a clock edge with W wait cycles leaves `ready_o` low for the next W cycles. `ready_o` then goes high in cycle W+1 after that edge, and read data for the control register appears in that same cycle. The bench drives inputs on the falling edge. Each access task counts the falling edges on which `ready_o` is low until it sees the ready cycle, and compares that count with the wait count required for the region. A behavioural model in the bench, built from an integer countdown and a copy of the register, predicts `ready_o` and the read data for every cycle. The bench compares it against the design on every falling edge, so an early, late, missing or doubled ready pulse is caught in the cycle where it happens.

// File: rtl/mwg_pkg.sv
package mwg_pkg;

  // Which timing class an address belongs to.
  typedef enum logic [1:0] {
    RGN_FLASH = 2'd0,
    RGN_MEM   = 2'd1,
    RGN_CTRL  = 2'd2
  } region_e;

endpackage

// File: rtl/mwg_decode.sv
module mwg_decode #(
  parameter int unsigned           ADDR_W    = 24,
  parameter logic [ADDR_W-1:0]     FLASH_TOP = 24'h400000,
  parameter logic [ADDR_W-1:0]     CTRL_ADDR = 24'hE00005
) (
  input  logic [ADDR_W-1:0] addr_i,
  output mwg_pkg::region_e  region_o
);

  // The control address takes precedence over the range checks.
  always_comb begin
    if (addr_i == CTRL_ADDR) begin
      region_o = mwg_pkg::RGN_CTRL;
    end else if (addr_i < FLASH_TOP) begin
      region_o = mwg_pkg::RGN_FLASH;
    end else begin
      region_o = mwg_pkg::RGN_MEM;
    end
  end

endmodule

// File: rtl/mwg_waitreg.sv
module mwg_waitreg #(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] value_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value_o <= RESET_VAL;
    end else if (wr_en) begin
      value_o <= wr_data;
    end
  end

  AST_REG_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> value_o == RESET_VAL); // R1

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(value_o)); // R8

endmodule

// File: rtl/mwg_counter.sv
module mwg_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             ready_o
);

  logic [CNT_W-1:0] remain_q;

  // A load of zero completes at once. Otherwise the counter runs down
  // to zero while ready stays low, then ready pulses for one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      remain_q <= '0;
      ready_o  <= 1'b0;
    end else if (start) begin
      if (load == '0) begin
        busy    <= 1'b0;
        ready_o <= 1'b1;
      end else begin
        busy     <= 1'b1;
        remain_q <= load - CNT_W'(1);
        ready_o  <= 1'b0;
      end
    end else if (busy) begin
      if (remain_q == '0) begin
        busy    <= 1'b0;
        ready_o <= 1'b1;
      end else begin
        remain_q <= remain_q - CNT_W'(1);
        ready_o  <= 1'b0;
      end
    end else begin
      ready_o <= 1'b0;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R8

  AST_LOAD_LATCH: assert property (@(posedge clk) disable iff (rst)
    (start && load != '0) |=> busy && remain_q == $past(load) - CNT_W'(1)); // R8

  AST_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready_o); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && remain_q != '0) |=> busy && remain_q == $past(remain_q) - CNT_W'(1)); // R2

  AST_FINISH_PULSE: assert property (@(posedge clk) disable iff (rst)
    (busy && remain_q == '0) |=> !busy && ready_o); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !ready_o); // R10

endmodule

// File: rtl/mem_wait_gen.sv
module mem_wait_gen #(
  parameter int unsigned       ADDR_W        = 24,
  parameter int unsigned       DATA_W        = 8,
  parameter logic [ADDR_W-1:0] FLASH_TOP     = 24'h400000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR     = 24'hE00005,
  parameter int unsigned       FLASH_BASE_WS = 5,
  parameter int unsigned       MEM_RD_WS     = 3,
  parameter int unsigned       MEM_WR_WS     = 1,
  parameter logic [DATA_W-1:0] REG_RESET     = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o
);

  // Wide enough for base + the largest register value.
  localparam int unsigned CNT_W = $clog2(FLASH_BASE_WS + (1 << DATA_W));

  mwg_pkg::region_e  region;
  logic              busy;
  logic              accept;
  logic              reg_wr;
  logic [DATA_W-1:0] reg_q;
  logic [CNT_W-1:0]  wait_cnt;

  assign accept = req_i && !busy;
  assign reg_wr = accept && we_i && (region == mwg_pkg::RGN_CTRL);

  mwg_decode #(
    .ADDR_W   (ADDR_W),
    .FLASH_TOP(FLASH_TOP),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr_i  (addr_i),
    .region_o(region)
  );

  mwg_waitreg #(
    .DATA_W   (DATA_W),
    .RESET_VAL(REG_RESET)
  ) u_waitreg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .wr_data(wdata_i),
    .value_o(reg_q)
  );

  // Wait count by region; flash reads and writes share one timing.
  always_comb begin
    unique case (region)
      mwg_pkg::RGN_FLASH: wait_cnt = CNT_W'(FLASH_BASE_WS) + CNT_W'(reg_q);
      mwg_pkg::RGN_MEM:   wait_cnt = we_i ? CNT_W'(MEM_WR_WS) : CNT_W'(MEM_RD_WS);
      default:            wait_cnt = '0;
    endcase
  end

  mwg_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .load   (wait_cnt),
    .busy   (busy),
    .ready_o(ready_o)
  );

  // Register read data is captured at acceptance, so it lines up with
  // the zero-wait ready pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (accept && !we_i && region == mwg_pkg::RGN_CTRL) begin
      rdata_o <= reg_q;
    end
  end

  AST_CTRL_ZERO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (accept && region == mwg_pkg::RGN_CTRL) |=> ready_o); // R6

  AST_MEM_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (accept && region != mwg_pkg::RGN_CTRL) |=> !ready_o && busy); // R3

  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    (accept && !we_i && region == mwg_pkg::RGN_CTRL) |=> rdata_o == $past(reg_q)); // R6

endmodule

// File: tb/tb_mem_wait_gen.sv
`timescale 1ns/1ps
module tb_mem_wait_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [23:0] CTRL  = 24'hE00005;
  localparam logic [23:0] FLASH = 24'h000100;
  localparam logic [23:0] RAM   = 24'hD00010;
  localparam logic [23:0] VRAM  = 24'hD40000;

  always #4 clk = ~clk;

  mem_wait_gen dut (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .ready_o(ready_o),
    .rdata_o(rdata_o)
  );

  // Behavioural reference model.
  int       m_rem = 0;
  bit       m_ready = 1'b0;
  bit       m_rdchk = 1'b0;
  int       m_reg = 4;
  int       m_rdata = 0;

  function automatic int exp_waits(logic [23:0] a, logic w, int regv);
    if (a == CTRL) return 0;
    if (a < 24'h400000) return 5 + regv;
    return w ? 1 : 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rem = 0; m_ready = 0; m_rdchk = 0; m_reg = 4;
    end else if (m_rem == 0) begin
      if (req_i) begin
        m_rem = exp_waits(addr_i, we_i, m_reg);
        m_ready = (m_rem == 0);
        m_rdchk = (addr_i == CTRL) && !we_i;
        if (m_rdchk) m_rdata = m_reg;
        if (addr_i == CTRL && we_i) m_reg = int'(wdata_i);
      end else begin
        m_ready = 0; m_rdchk = 0;
      end
    end else begin
      m_rem = m_rem - 1;
      m_ready = (m_rem == 0);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (ready_o !== m_ready) begin
        errors++;
        $display("FAIL R10 ready per-cycle: got %0b expected %0b at cycle %0d", ready_o, m_ready, cycles);
      end
      if (m_ready && m_rdchk) begin
        checks++;
        if (rdata_o !== 8'(m_rdata)) begin
          errors++;
          $display("FAIL R6 model readback: got %02h expected %02h", rdata_o, 8'(m_rdata));
        end
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Starts at a falling edge, presents one request, returns at the falling
  // edge where ready is seen. Counts low cycles in between.
  task automatic access(input logic [23:0] a, input logic w, input logic [7:0] d,
                        input int exp_w, input string tag,
                        input bit chk_data, input logic [7:0] exp_d);
    int n = 0;
    req_i = 1'b1; addr_i = a; we_i = w; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    while (!ready_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != exp_w) begin
      errors++;
      $display("FAIL %s waits: got %0d expected %0d", tag, n, exp_w);
    end
    if (chk_data) begin
      checks++;
      if (rdata_o !== exp_d) begin
        errors++;
        $display("FAIL %s data: got %02h expected %02h", tag, rdata_o, exp_d);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (ready_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 ready after reset: got %0b expected 0", ready_o);
    end
    access(CTRL, 1'b0, 8'h00, 0, "R1", 1'b1, 8'h04);
    idle(2);
    access(FLASH, 1'b0, 8'h00, 9, "R2", 1'b0, 8'h00);
    idle(1);
    access(RAM, 1'b0, 8'h00, 3, "R3", 1'b0, 8'h00);
    access(VRAM, 1'b0, 8'h00, 3, "R3", 1'b0, 8'h00);
    idle(1);
    access(RAM, 1'b1, 8'h00, 1, "R4", 1'b0, 8'h00);
    access(VRAM, 1'b1, 8'h00, 1, "R4", 1'b0, 8'h00);
    idle(2);
    access(24'h001000, 1'b1, 8'h00, 9, "R5", 1'b0, 8'h00);
    idle(1);
    access(CTRL, 1'b1, 8'h00, 0, "R6", 1'b0, 8'h00);
    access(FLASH, 1'b0, 8'h00, 5, "R7", 1'b0, 8'h00);
    access(24'h3FFFFF, 1'b1, 8'h00, 5, "R5", 1'b0, 8'h00);
    access(CTRL, 1'b0, 8'h00, 0, "R6", 1'b1, 8'h00);
    access(CTRL, 1'b1, 8'hFF, 0, "R6", 1'b0, 8'h00);
    access(FLASH, 1'b0, 8'h00, 260, "R7", 1'b0, 8'h00);
    access(CTRL, 1'b0, 8'h00, 0, "R6", 1'b1, 8'hFF);
    access(CTRL, 1'b1, 8'h2A, 0, "R6", 1'b0, 8'h00);
    access(CTRL, 1'b0, 8'h00, 0, "R6", 1'b1, 8'h2A);
    access(FLASH, 1'b0, 8'h00, 47, "R2", 1'b0, 8'h00);
    access(CTRL, 1'b1, 8'h04, 0, "R9", 1'b0, 8'h00);
    idle(3);
    // R8: register write presented mid-access is ignored.
    begin
      int n = 0;
      req_i = 1'b1; addr_i = FLASH; we_i = 1'b0;
      @(negedge clk);
      req_i = 1'b0;
      while (!ready_o && n < 1000) begin
        n++;
        if (n == 3) begin
          req_i = 1'b1; addr_i = CTRL; we_i = 1'b1; wdata_i = 8'h10;
        end else begin
          req_i = 1'b0;
        end
        @(negedge clk);
      end
      req_i = 1'b0;
      checks++;
      if (n != 9) begin
        errors++;
        $display("FAIL R8 waits with busy write: got %0d expected 9", n);
      end
    end
    idle(1);
    access(CTRL, 1'b0, 8'h00, 0, "R8", 1'b1, 8'h04);
    // R9: chained accesses with no idle gap.
    access(RAM, 1'b0, 8'h00, 3, "R9", 1'b0, 8'h00);
    access(FLASH, 1'b0, 8'h00, 9, "R9", 1'b0, 8'h00);
    access(RAM, 1'b1, 8'h00, 1, "R9", 1'b0, 8'h00);
    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule